// File: doc/BRIEF.md
# Handshaked Accumulator Processor

A small accumulator machine whose control is a step sequencer talking to three datapath servers over four-phase request/acknowledge pairs. The servers are a program-counter incrementer, an instruction fetcher that copies the program byte at the current PC into the instruction register, and an ALU that owns the 8-bit accumulator. The ALU can load the accumulator from the instruction register, decrement it, or load the PC from the instruction register. In every step the sequencer raises the requests of one or more servers. It waits until every one of them has acknowledged, drops the requests, and waits for the acknowledges to fall before it moves to the next step.

Five instruction classes exist: no-op, load-immediate, decrement, branch-if-nonzero and unconditional jump. An immediate value or a branch target sits in the byte that follows the opcode. After reset the first opcode byte is fetched at once. Execution then waits for a start pulse, and from that point it runs without stopping. The end of every instruction is marked by a one-cycle retire pulse.

Top module: `hsk_acc_cpu`

## Requirements
- R1: After reset the PC and the accumulator are 0, no retire pulse appears, and the PC does not move until start_i is seen high.
- R2: An opcode whose low three bits are 0, 5, 6 or 7 advances the PC by one and leaves the accumulator unchanged.
- R3: Opcode class 1 (load-immediate) copies the following byte into the accumulator and advances the PC by two.
- R4: Opcode class 2 (decrement) lowers the accumulator by one modulo 256 (0 becomes FF) and advances the PC by one.
- R5: Opcode class 3 (branch-if-nonzero) loads the PC with the following byte when the accumulator is nonzero at the start of the instruction, and otherwise advances the PC by two.
- R6: Opcode class 4 (jump) loads the PC with the following byte; the accumulator is unchanged.
- R7: Only the low three opcode bits select the class; the upper five bits are ignored (for example, FA behaves as a decrement).
- R8: The PC is 8 bits wide and wraps from FF to 00.
- R9: Each handshake step takes 4 cycles. Retire pulses are therefore 8 cycles apart for no-op and decrement, 12 for a branch that is not taken, and 16 for load-immediate, jump and a taken branch. done_o is high for exactly one cycle, and pc_o and acc_o already show the results of the retired instruction while it is high.
- R10: Each server raises its acknowledge one cycle after it sees its request and drops it one cycle after the request falls. A request stays high until it is acknowledged, and the ALU never loads the PC in the same cycle as an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that begins continuous execution |
| imem_addr_o | output | 8 | Program memory read address (equal to the PC) |
| imem_data_i | input | 8 | Program memory byte at imem_addr_o, combinational |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | High when the accumulator is zero |
| done_o | output | 1 | One-cycle retire pulse per instruction |

## Verification
Each instruction's result is due on the cycle of its retire pulse. That pulse comes 4 cycles per handshake step after the previous one, so 8, 12 or 16 cycles depending on the class and the branch outcome. The bench waits on done_o at falling edges, counts the falling edges between pulses, and compares PC, accumulator and interval in that cycle against a hand-computed trace. The first instruction after start only has its results compared, because its interval includes the wait for start. A second program runs the reload-and-count-down loop through all 255 decrements and checks that the branch falls through exactly when the count reaches zero.

// File: rtl/hsk_cpu_pkg.sv
package hsk_cpu_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int OPC_W  = 3;
    localparam int IDX_W  = 2;

    localparam logic [OPC_W-1:0] OPC_NOP = 3'd0;
    localparam logic [OPC_W-1:0] OPC_MOV = 3'd1;
    localparam logic [OPC_W-1:0] OPC_DEC = 3'd2;
    localparam logic [OPC_W-1:0] OPC_JNZ = 3'd3;
    localparam logic [OPC_W-1:0] OPC_JMP = 3'd4;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_LDA  = 2'd1,
        ALU_LDPC = 2'd2,
        ALU_DEC  = 2'd3
    } alu_op_e;

    // One handshake step: which servers fire together, and whether it ends the instruction
    typedef struct packed {
        logic    pcu;
        logic    ifu;
        logic    alu;
        alu_op_e aop;
        logic    last;
    } ustep_t;

    function automatic ustep_t mk_step(logic p, logic f, alu_op_e a, logic l);
        ustep_t s;
        s.pcu  = p;
        s.ifu  = f;
        s.alu  = (a != ALU_NONE);
        s.aop  = a;
        s.last = l;
        return s;
    endfunction

    localparam ustep_t BOOT_STEP = '{pcu: 1'b0, ifu: 1'b1, alu: 1'b0, aop: ALU_NONE, last: 1'b1};

    // Step schedule per instruction class; z is the zero flag taken at instruction start
    function automatic ustep_t step_of(logic [OPC_W-1:0] opc, logic z, logic [IDX_W-1:0] idx);
        ustep_t s;
        s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b1);
        case (opc)
            OPC_MOV: begin
                case (idx)
                    2'd0:    s = mk_step(1'b1, 1'b0, ALU_NONE, 1'b0);
                    2'd1:    s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b0);
                    2'd2:    s = mk_step(1'b1, 1'b0, ALU_LDA,  1'b0);
                    default: s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b1);
                endcase
            end
            OPC_DEC: begin
                if (idx == 2'd0) s = mk_step(1'b1, 1'b0, ALU_DEC, 1'b0);
                else             s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b1);
            end
            OPC_JNZ, OPC_JMP: begin
                if (opc == OPC_JNZ && z) begin
                    case (idx)
                        2'd0:    s = mk_step(1'b1, 1'b0, ALU_NONE, 1'b0);
                        2'd1:    s = mk_step(1'b1, 1'b0, ALU_NONE, 1'b0);
                        default: s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b1);
                    endcase
                end else begin
                    case (idx)
                        2'd0:    s = mk_step(1'b1, 1'b0, ALU_NONE, 1'b0);
                        2'd1:    s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b0);
                        2'd2:    s = mk_step(1'b0, 1'b0, ALU_LDPC, 1'b0);
                        default: s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b1);
                    endcase
                end
            end
            default: begin
                if (idx == 2'd0) s = mk_step(1'b1, 1'b0, ALU_NONE, 1'b0);
                else             s = mk_step(1'b0, 1'b1, ALU_NONE, 1'b1);
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hsk_pc_unit.sv
module hsk_pc_unit
    import hsk_cpu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    output logic          ack,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] pc
);
    logic fire;
    assign fire = req && !ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            pc  <= '0;
        end else begin
            ack <= req;
            if (fire)         pc <= pc + 1'b1;
            else if (load_en) pc <= load_val;
        end
    end
endmodule

// File: rtl/hsk_fetch_unit.sv
module hsk_fetch_unit
    import hsk_cpu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    output logic          ack,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data,
    output logic [DW-1:0] ir
);
    logic fire;
    assign fire     = req && !ack;
    assign mem_addr = pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            ir  <= '0;
        end else begin
            ack <= req;
            if (fire) ir <= mem_data;
        end
    end
endmodule

// File: rtl/hsk_alu_unit.sv
module hsk_alu_unit
    import hsk_cpu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    output logic          ack,
    input  alu_op_e       op,
    input  logic [DW-1:0] ir,
    output logic [DW-1:0] acc,
    output logic          zero,
    output logic          pc_load_en,
    output logic [AW-1:0] pc_load_val
);
    logic fire;
    assign fire        = req && !ack;
    assign zero        = (acc == '0);
    assign pc_load_en  = fire && (op == ALU_LDPC);
    assign pc_load_val = ir[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            acc <= '0;
        end else begin
            ack <= req;
            if (fire) begin
                case (op)
                    ALU_LDA: acc <= ir;
                    ALU_DEC: acc <= acc - 1'b1;
                    default: acc <= acc;
                endcase
            end
        end
    end
endmodule

// File: rtl/hsk_sequencer.sv
module hsk_sequencer
    import hsk_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [OPC_W-1:0] ir_opc,
    input  logic             zero_i,
    input  logic             pcu_ack,
    input  logic             ifu_ack,
    input  logic             alu_ack,
    output logic             pcu_req,
    output logic             ifu_req,
    output logic             alu_req,
    output alu_op_e          alu_op,
    output logic             done_o
);
    typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_REL} sq_state_e;

    sq_state_e        state_q;
    logic             boot_q;
    logic             run_q;
    logic [OPC_W-1:0] op_q;
    logic             z_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    ustep_t           cur;
    logic             in_req, all_ack, none_ack;

    always_comb begin
        cur = boot_q ? BOOT_STEP : step_of(op_q, z_q, idx_q);
    end

    assign in_req   = (state_q == SQ_REQ);
    assign pcu_req  = in_req && cur.pcu;
    assign ifu_req  = in_req && cur.ifu;
    assign alu_req  = in_req && cur.alu;
    assign alu_op   = cur.aop;
    assign all_ack  = (!cur.pcu || pcu_ack) && (!cur.ifu || ifu_ack) && (!cur.alu || alu_ack);
    assign none_ack = !(pcu_ack || ifu_ack || alu_ack);
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_REQ;
            boot_q  <= 1'b1;
            run_q   <= 1'b0;
            op_q    <= '0;
            z_q     <= 1'b0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) run_q <= 1'b1;
            case (state_q)
                SQ_IDLE: begin
                    if (run_q || start_i) begin
                        op_q    <= ir_opc;
                        z_q     <= zero_i;
                        idx_q   <= '0;
                        state_q <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    if (all_ack) state_q <= SQ_REL;
                end
                SQ_REL: begin
                    if (none_ack) begin
                        if (boot_q) begin
                            boot_q  <= 1'b0;
                            state_q <= SQ_IDLE;
                        end else if (cur.last) begin
                            done_q  <= 1'b1;
                            op_q    <= ir_opc;
                            z_q     <= zero_i;
                            idx_q   <= '0;
                            state_q <= SQ_REQ;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SQ_REQ;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsk_acc_cpu.sv
module hsk_acc_cpu
    import hsk_cpu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int DATA_W_P = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    output logic [ADDR_W_P-1:0] imem_addr_o,
    input  logic [DATA_W_P-1:0] imem_data_i,
    output logic [ADDR_W_P-1:0] pc_o,
    output logic [DATA_W_P-1:0] acc_o,
    output logic                zero_o,
    output logic                done_o
);
    logic                pcu_req, pcu_ack, ifu_req, ifu_ack, alu_req, alu_ack;
    logic                pc_load_en;
    logic [ADDR_W_P-1:0] pc_load_val;
    logic [ADDR_W_P-1:0] pc_q;
    logic [DATA_W_P-1:0] ir_q;
    logic [DATA_W_P-1:0] acc_q;
    logic                zero_w;
    alu_op_e             alu_op;

    hsk_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ir_opc  (ir_q[OPC_W-1:0]),
        .zero_i  (zero_w),
        .pcu_ack (pcu_ack),
        .ifu_ack (ifu_ack),
        .alu_ack (alu_ack),
        .pcu_req (pcu_req),
        .ifu_req (ifu_req),
        .alu_req (alu_req),
        .alu_op  (alu_op),
        .done_o  (done_o)
    );

    hsk_pc_unit #(.AW(ADDR_W_P)) u_pcu (
        .clk      (clk),
        .rst      (rst),
        .req      (pcu_req),
        .ack      (pcu_ack),
        .load_en  (pc_load_en),
        .load_val (pc_load_val),
        .pc       (pc_q)
    );

    hsk_fetch_unit #(.AW(ADDR_W_P), .DW(DATA_W_P)) u_ifu (
        .clk      (clk),
        .rst      (rst),
        .req      (ifu_req),
        .ack      (ifu_ack),
        .pc       (pc_q),
        .mem_addr (imem_addr_o),
        .mem_data (imem_data_i),
        .ir       (ir_q)
    );

    hsk_alu_unit #(.AW(ADDR_W_P), .DW(DATA_W_P)) u_alu (
        .clk         (clk),
        .rst         (rst),
        .req         (alu_req),
        .ack         (alu_ack),
        .op          (alu_op),
        .ir          (ir_q),
        .acc         (acc_q),
        .zero        (zero_w),
        .pc_load_en  (pc_load_en),
        .pc_load_val (pc_load_val)
    );

    assign pc_o   = pc_q;
    assign acc_o  = acc_q;
    assign zero_o = zero_w;
endmodule

// File: rtl/hsk_acc_cpu_chk.sv
module hsk_acc_cpu_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          pcu_req,
    input logic          pcu_ack,
    input logic          ifu_req,
    input logic          ifu_ack,
    input logic          alu_req,
    input logic          alu_ack,
    input logic          pc_load_en,
    input logic          done_o,
    input logic [AW-1:0] pc_q,
    input logic [DW-1:0] acc_q
);
    // R10
    pcu_ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        pcu_req && !pcu_ack |=> pcu_ack);
    // R10
    pcu_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !pcu_req && pcu_ack |=> !pcu_ack);
    // R10
    ifu_ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ifu_req && !ifu_ack |=> ifu_ack);
    // R10
    ifu_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !ifu_req && ifu_ack |=> !ifu_ack);
    // R10
    alu_ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        alu_req && !alu_ack |=> alu_ack);
    // R10
    alu_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !alu_req && alu_ack |=> !alu_ack);
    // R10
    ifu_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ifu_req && !ifu_ack |=> ifu_req);
    // R10
    pc_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_load_en && pcu_req && !pcu_ack));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R8
    pc_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_q) |-> ($past(pcu_req && !pcu_ack) || $past(pc_load_en)));
    // R4
    acc_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> $past(alu_req && !alu_ack));
endmodule

bind hsk_acc_cpu hsk_acc_cpu_chk #(.AW(ADDR_W_P), .DW(DATA_W_P)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pcu_req    (pcu_req),
    .pcu_ack    (pcu_ack),
    .ifu_req    (ifu_req),
    .ifu_ack    (ifu_ack),
    .alu_req    (alu_req),
    .alu_ack    (alu_ack),
    .pc_load_en (pc_load_en),
    .done_o     (done_o),
    .pc_q       (pc_q),
    .acc_q      (acc_q)
);

// File: tb/hsk_acc_cpu_tb.sv
module hsk_acc_cpu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] imem_addr_o, imem_data_i, pc_o, acc_o;
    logic       zero_o, done_o;
    logic [7:0] mem [256];
    int         checks = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    assign imem_data_i = mem[imem_addr_o];

    hsk_acc_cpu u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .imem_addr_o (imem_addr_o),
        .imem_data_i (imem_data_i),
        .pc_o        (pc_o),
        .acc_o       (acc_o),
        .zero_o      (zero_o),
        .done_o      (done_o)
    );

    // Program bytes {addr, data}
    localparam logic [15:0] PROG [20] = '{
        16'h00_01, 16'h01_05, 16'h02_02, 16'h03_00, 16'h04_04, 16'h05_08,
        16'h08_02, 16'h09_01, 16'h0A_01, 16'h0B_02, 16'h0C_03, 16'h0D_14,
        16'h0E_02, 16'h0F_03, 16'h10_1E, 16'h1E_07, 16'h1F_FA, 16'h20_04,
        16'h21_FF, 16'hFF_05
    };
    // Expected after each retire {pc, acc, interval}
    localparam logic [23:0] EXP [15] = '{
        24'h02_05_10, // R3 load 5
        24'h03_04_08, // R4 decrement
        24'h04_04_08, // R2 no-op
        24'h08_04_10, // R6 jump
        24'h09_03_08, // R4
        24'h0B_01_10, // R3
        24'h0C_00_08, // R4 reaches zero
        24'h0E_00_0C, // R5 not taken
        24'h0F_FF_08, // R4 wrap 0 -> FF
        24'h1E_FF_10, // R5 taken
        24'h1F_FF_08, // R2 code 7
        24'h20_FE_08, // R7 FA acts as decrement
        24'hFF_FE_10, // R6 jump to FF
        24'h00_FE_08, // R8 wrap, code 5 no-op
        24'h02_05_10  // R3
    };

    function automatic string tag_of(int i);
        case (i)
            0, 5, 14:    return "R3";
            1, 4, 6, 8:  return "R4";
            2, 10:       return "R2";
            3, 12:       return "R6";
            7, 9:        return "R5";
            11:          return "R7";
            default:     return "R8";
        endcase
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done_o && n < 2000);
        if (!done_o) chk("R9 retire timeout", 32'(n), 32'd0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int  n;
        logic seen_done;
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        for (int p = 0; p < 20; p++) mem[PROG[p][15:8]] = PROG[p][7:0];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", 32'(pc_o), 32'h0);
        chk("R1 acc", 32'(acc_o), 32'h0);
        chk("R1 zero", 32'(zero_o), 32'h1);
        seen_done = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done_o) seen_done = 1'b1;
        end
        chk("R1 pc held", 32'(pc_o), 32'h0);
        chk("R1 no retire", 32'(seen_done), 32'h0);

        pulse_start();
        for (int i = 0; i < 15; i++) begin
            wait_done(n);
            chk({tag_of(i), " pc"}, 32'(pc_o), 32'(EXP[i][23:16]));
            chk({tag_of(i), " acc"}, 32'(acc_o), 32'(EXP[i][15:8]));
            if (i > 0) chk("R9 interval", 32'(n), 32'(EXP[i][7:0]));
        end
        @(negedge clk);
        chk("R9 single-cycle retire", 32'(done_o), 32'h0);

        // Reference loop: load FF, count down, jump back
        rst = 1'b1;
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        mem[0] = 8'h01; mem[1] = 8'hFF; mem[2] = 8'h02;
        mem[3] = 8'h03; mem[4] = 8'h02; mem[5] = 8'h04; mem[6] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 pc after second reset", 32'(pc_o), 32'h0);
        pulse_start();
        wait_done(n);
        chk("R3 loop load", 32'(acc_o), 32'hFF);
        for (int k = 1; k <= 255; k++) begin
            wait_done(n);
            chk("R4 loop dec", 32'(acc_o), 32'(8'hFF - k[7:0]));
            wait_done(n);
            chk("R5 loop branch", 32'(pc_o), (k < 255) ? 32'h2 : 32'h5);
            chk("R9 loop branch interval", 32'(n), (k < 255) ? 32'd16 : 32'd12);
        end
        wait_done(n);
        chk("R6 loop jump", 32'(pc_o), 32'h0);
        wait_done(n);
        chk("R3 loop reload", 32'(acc_o), 32'hFF);
        chk("R3 loop reload pc", 32'(pc_o), 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule